// File: doc/BRIEF.md
# Interrupt Pending and Active State Tracker

This block keeps two state bits for each line in a bank of peripheral interrupt inputs: one says that the line is waiting for service (pending) and one says that its handler is running (active). Each line is set up as either level-sensitive or pulse type. A level line stays pending for as long as its input is high and the interrupt is not active. A pulse line is latched on a rising edge, so a pulse that lasts only one clock cycle is still caught. Software can also make any line pending by writing its number to a trigger register.

The core reports handler entry and handler return with one-cycle strobes, each carrying an interrupt number. Entry moves an interrupt from pending to active. Return clears active. On return, a level line is sampled again and goes back to pending if its input is still high. Choosing which pending interrupt to serve, fetching vectors and stacking are left to other logic. This block only supplies the pending and active vectors that such logic uses.

Unprivileged trigger writes are gated by a control bit, and only privileged writes can change that bit. All state updates on the rising clock edge, and every output comes straight from a register.

Top module: `irq_state_tracker`

## Requirements
- R1: A synchronous active-high reset clears every pending bit, every active bit, the user-trigger control bit and the rising-edge history. A pulse line that is held high when reset is released therefore becomes pending on the first clock edge after reset.
- R2: A line configured as level type (`irq_is_pulse[i]=0`) becomes pending on the clock edge at which its input is sampled high while the interrupt is neither active nor being entered.
- R3: A line configured as pulse type (`irq_is_pulse[i]=1`) becomes pending on the clock edge at which its input is sampled high after having been low at the previous edge. A one-cycle pulse is caught. A level held high afterwards does not make the line pending again.
- R4: A write with `wr_sel=0` (trigger register) that is allowed makes pending the line whose number is in `wr_data[8:0]`. Bits `wr_data[31:9]` have no effect, and exactly one line is affected.
- R5: A trigger write whose number is equal to or greater than `N_IRQ` (240 to 511 by default) changes no state.
- R6: A write with `wr_sel=1` (control register) and `wr_priv=1` loads `wr_data[0]` into the user-trigger enable bit. A control write with `wr_priv=0` is ignored. A trigger write with `wr_priv=0` takes effect only when that bit is 1, while a privileged trigger write always takes effect.
- R7: An `isr_enter` strobe for interrupt n clears pending bit n and sets active bit n on that clock edge, unless a new request for n arrives in the same cycle.
- R8: An `isr_exit` strobe for a level-type interrupt n clears active bit n on that edge. In the same edge, pending bit n is set if the input is high and stays clear if the input is low.
- R9: A rising edge on a pulse line whose interrupt is active sets its pending bit. A return from a pulse interrupt clears its active bit and leaves its pending bit unchanged.
- R10: While a level-type interrupt is active, a high input does not set its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_IRQ | Raw interrupt lines from peripherals |
| irq_is_pulse | input | N_IRQ | Per-line type: 1 = pulse, 0 = level |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select: 0 = trigger, 1 = control |
| wr_data | input | 32 | Write data |
| wr_priv | input | 1 | 1 when the write is privileged |
| isr_enter | input | 1 | Core is entering a handler |
| isr_enter_id | input | 9 | Interrupt number being entered |
| isr_exit | input | 1 | Core is returning from a handler |
| isr_exit_id | input | 9 | Interrupt number being returned from |
| pend_o | output | N_IRQ | Pending bit per line |
| active_o | output | N_IRQ | Active bit per line |
| user_trig_en_o | output | 1 | Current user-trigger enable bit |

## Verification
The assertions check every line on every cycle for the following: level and pulse requests turn into pending bits one edge later, handler entry clears pending and sets active, a level return with the input high goes back to pending, an active level line never re-pends, and the control bit changes only on a privileged control write. They also check that the software decode produces at most one hit per cycle and none for a blocked unprivileged write. Only the bench scenarios can show behaviour that spans several events. These are: reset release with a line held high, a short pulse arriving while its handler runs, a level line serviced twice, upper trigger data bits being ignored, out-of-range numbers being dropped, and the full sequence of changing the user-trigger permission.

// File: rtl/irqt_pkg.sv
package irqt_pkg;
  localparam int ID_W  = 9;
  localparam int REG_W = 32;

  typedef enum logic {
    SEL_TRIG = 1'b0,
    SEL_CTRL = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irqt_id_decode.sv
module irqt_id_decode #(
  parameter int N  = 240,
  parameter int IW = 9
) (
  input  logic          en,
  input  logic [IW-1:0] id,
  output logic [N-1:0]  hit
);
  // numbers at or above N match no output bit and are dropped
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign hit[i] = en && (id == IW'(i));
  end
endmodule

// File: rtl/irqt_sw_trig.sv
module irqt_sw_trig
  import irqt_pkg::*;
#(
  parameter int N  = 240,
  parameter int IW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_priv,
  output logic          ctl_q,
  output logic [N-1:0]  trig_vec
);
  logic trig_ok;
  logic ctl_wr;
  logic unused_hi;

  assign unused_hi = ^wr_data[DW-1:IW];
  assign ctl_wr    = wr_en && wr_priv && (wr_sel == SEL_CTRL);
  assign trig_ok   = wr_en && (wr_sel == SEL_TRIG) && (wr_priv || ctl_q);

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= 1'b0;
    else if (ctl_wr) ctl_q <= wr_data[0];
  end

  irqt_id_decode #(.N(N), .IW(IW)) u_dec (
    .en  (trig_ok),
    .id  (wr_data[IW-1:0]),
    .hit (trig_vec)
  );

  // R4
  trig_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(trig_vec));

  // R6
  user_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_priv && !ctl_q) |-> (trig_vec == '0));

  // R6
  ctl_guard_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_priv && wr_sel == SEL_CTRL) |=> $stable(ctl_q));
endmodule

// File: rtl/irqt_line_bank.sv
module irqt_line_bank #(
  parameter int N = 240
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] irq_in,
  input  logic [N-1:0] is_pulse,
  input  logic [N-1:0] ent_hit,
  input  logic [N-1:0] ext_hit,
  input  logic [N-1:0] sw_hit,
  output logic [N-1:0] pend_q,
  output logic [N-1:0] act_q
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic prev_q, p_q, a_q;
    logic act_n, pend_n, edge_s, lvl_s;

    always_comb begin
      // entry wins over return if both name this line in one cycle
      act_n  = (a_q & ~ext_hit[i]) | ent_hit[i];
      edge_s = is_pulse[i] & irq_in[i] & ~prev_q;
      // level lines pend only while not active in the next state, so
      // a return re-samples the input in the same edge that clears active
      lvl_s  = ~is_pulse[i] & irq_in[i] & ~act_n;
      pend_n = (p_q & ~ent_hit[i]) | edge_s | lvl_s | sw_hit[i];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_q <= 1'b0;
        p_q    <= 1'b0;
        a_q    <= 1'b0;
      end else begin
        prev_q <= irq_in[i];
        p_q    <= pend_n;
        a_q    <= act_n;
      end
    end

    assign pend_q[i] = p_q;
    assign act_q[i]  = a_q;

    // R2
    level_pend_chk: assert property (@(posedge clk) disable iff (rst)
      (!is_pulse[i] && irq_in[i] && !a_q && !ent_hit[i]) |=> p_q);

    // R3
    edge_pend_chk: assert property (@(posedge clk) disable iff (rst)
      (is_pulse[i] && irq_in[i] && !prev_q) |=> p_q);

    // R7
    enter_move_chk: assert property (@(posedge clk) disable iff (rst)
      (ent_hit[i] && !sw_hit[i] && !edge_s) |=> (!p_q && a_q));

    // R8
    exit_resample_chk: assert property (@(posedge clk) disable iff (rst)
      (ext_hit[i] && !ent_hit[i] && !is_pulse[i] && irq_in[i]) |=> (p_q && !a_q));

    // R10
    active_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (a_q && !p_q && !ext_hit[i] && !is_pulse[i] && !sw_hit[i]) |=> !p_q);
  end
endmodule

// File: rtl/irq_state_tracker.sv
module irq_state_tracker
  import irqt_pkg::*;
#(
  parameter int N_IRQ = 240
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic [N_IRQ-1:0] irq_is_pulse,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             wr_priv,
  input  logic             isr_enter,
  input  logic [ID_W-1:0]  isr_enter_id,
  input  logic             isr_exit,
  input  logic [ID_W-1:0]  isr_exit_id,
  output logic [N_IRQ-1:0] pend_o,
  output logic [N_IRQ-1:0] active_o,
  output logic             user_trig_en_o
);
  localparam int MAX_LINES = 1 << ID_W;

  logic [N_IRQ-1:0] ent_hit, ext_hit, sw_hit;

  initial begin
    if (N_IRQ > MAX_LINES || N_IRQ < 1)
      $error("N_IRQ out of range for the interrupt number width");
  end

  irqt_sw_trig #(.N(N_IRQ), .IW(ID_W), .DW(REG_W)) u_sw (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .wr_priv  (wr_priv),
    .ctl_q    (user_trig_en_o),
    .trig_vec (sw_hit)
  );

  irqt_id_decode #(.N(N_IRQ), .IW(ID_W)) u_ent_dec (
    .en  (isr_enter),
    .id  (isr_enter_id),
    .hit (ent_hit)
  );

  irqt_id_decode #(.N(N_IRQ), .IW(ID_W)) u_ext_dec (
    .en  (isr_exit),
    .id  (isr_exit_id),
    .hit (ext_hit)
  );

  irqt_line_bank #(.N(N_IRQ)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .irq_in   (irq_in),
    .is_pulse (irq_is_pulse),
    .ent_hit  (ent_hit),
    .ext_hit  (ext_hit),
    .sw_hit   (sw_hit),
    .pend_q   (pend_o),
    .act_q    (active_o)
  );

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pend_o == '0 && active_o == '0 && !user_trig_en_o));
endmodule

// File: tb/irq_state_tracker_test.sv
module irq_state_tracker_test;
  localparam int N = 240;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] irq_in, irq_is_pulse;
  logic wr_en, wr_sel, wr_priv;
  logic [31:0] wr_data;
  logic isr_enter, isr_exit;
  logic [8:0] isr_enter_id, isr_exit_id;
  logic [N-1:0] pend_o, active_o;
  logic user_trig_en_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  irq_state_tracker #(.N_IRQ(N)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .irq_is_pulse(irq_is_pulse),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .wr_priv(wr_priv),
    .isr_enter(isr_enter), .isr_enter_id(isr_enter_id),
    .isr_exit(isr_exit), .isr_exit_id(isr_exit_id),
    .pend_o(pend_o), .active_o(active_o), .user_trig_en_o(user_trig_en_o)
  );

  always #10 clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic sel, logic [31:0] data, logic priv);
    wr_en = 1'b1; wr_sel = sel; wr_data = data; wr_priv = priv;
    tick();
    wr_en = 1'b0; wr_data = '0; wr_priv = 1'b0;
  endtask

  task automatic enter(int id);
    isr_enter = 1'b1; isr_enter_id = 9'(id);
    tick();
    isr_enter = 1'b0;
  endtask

  task automatic leave(int id);
    isr_exit = 1'b1; isr_exit_id = 9'(id);
    tick();
    isr_exit = 1'b0;
  endtask

  // reset state and edge history cleared
  task automatic t_reset();
    rst = 1'b1;
    irq_in[5] = 1'b1;
    tick(); tick();
    chk("R1 pend after reset", 32'($countones(pend_o)), 0);
    chk("R1 active after reset", 32'($countones(active_o)), 0);
    chk("R1 ctl bit after reset", 32'(user_trig_en_o), 0);
    rst = 1'b0;
    tick();
    chk("R1 held pulse pends after release", 32'(pend_o[5]), 1);
    tick();
    enter(5);
    chk("R7 enter clears pend", 32'(pend_o[5]), 0);
    chk("R7 enter sets active", 32'(active_o[5]), 1);
    tick();
    chk("R3 held pulse no re-pend", 32'(pend_o[5]), 0);
    leave(5);
    chk("R9 pulse exit clears active", 32'(active_o[5]), 0);
    chk("R9 pulse exit leaves pend clear", 32'(pend_o[5]), 0);
    irq_in[5] = 1'b0;
    tick();
  endtask

  // level line serviced twice, then released
  task automatic t_level();
    irq_in[10] = 1'b1;
    tick();
    chk("R2 level pends", 32'(pend_o[10]), 1);
    enter(10);
    chk("R7 level enter", 32'({pend_o[10], active_o[10]}), 32'b01);
    tick(); tick();
    chk("R10 active level no re-pend", 32'(pend_o[10]), 0);
    leave(10);
    chk("R8 exit high re-pends", 32'({pend_o[10], active_o[10]}), 32'b10);
    enter(10);
    irq_in[10] = 1'b0;
    leave(10);
    chk("R8 exit low goes inactive", 32'({pend_o[10], active_o[10]}), 32'b00);
  endtask

  // short pulses, including one during service
  task automatic t_pulse();
    irq_in[239] = 1'b1;
    tick();
    irq_in[239] = 1'b0;
    chk("R3 one-cycle pulse caught", 32'(pend_o[239]), 1);
    enter(239);
    chk("R7 pulse enter", 32'({pend_o[239], active_o[239]}), 32'b01);
    irq_in[239] = 1'b1;
    tick();
    irq_in[239] = 1'b0;
    chk("R9 edge while active pends", 32'({pend_o[239], active_o[239]}), 32'b11);
    leave(239);
    chk("R9 pulse exit keeps pend", 32'({pend_o[239], active_o[239]}), 32'b10);
    enter(239);
    leave(239);
    chk("R9 pulse cleaned", 32'({pend_o[239], active_o[239]}), 32'b00);
  endtask

  // privileged trigger with junk in upper bits
  task automatic t_sw_trig();
    reg_write(1'b0, 32'hFFFF_FE03, 1'b1);
    chk("R4 trigger line 3", 32'(pend_o[3]), 1);
    chk("R4 exactly one line", 32'($countones(pend_o)), 1);
    enter(3);
    leave(3);
    chk("R4 cleanup", 32'($countones(pend_o)), 0);
  endtask

  task automatic t_range();
    reg_write(1'b0, 32'd240, 1'b1);
    chk("R5 id 240 dropped", 32'($countones(pend_o)), 0);
    reg_write(1'b0, 32'h0000_01FF, 1'b1);
    chk("R5 id 511 dropped", 32'($countones(pend_o) + $countones(active_o)), 0);
  endtask

  task automatic t_user();
    reg_write(1'b0, 32'd7, 1'b0);
    chk("R6 unpriv blocked", 32'(pend_o[7]), 0);
    reg_write(1'b1, 32'd1, 1'b0);
    chk("R6 unpriv ctl write ignored", 32'(user_trig_en_o), 0);
    reg_write(1'b1, 32'd1, 1'b1);
    chk("R6 priv ctl write", 32'(user_trig_en_o), 1);
    reg_write(1'b0, 32'd7, 1'b0);
    chk("R6 unpriv allowed", 32'(pend_o[7]), 1);
    reg_write(1'b1, 32'd0, 1'b1);
    chk("R6 ctl cleared", 32'(user_trig_en_o), 0);
    enter(7);
    leave(7);
  endtask

  initial begin
    rst = 1'b1;
    irq_in = '0;
    irq_is_pulse = '0;
    irq_is_pulse[5] = 1'b1;
    irq_is_pulse[239] = 1'b1;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; wr_priv = 1'b0;
    isr_enter = 1'b0; isr_exit = 1'b0;
    isr_enter_id = '0; isr_exit_id = '0;
    #1;
    t_reset();
    t_level();
    t_pulse();
    t_sw_trig();
    t_range();
    t_user();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule